// File: doc/BRIEF.md
# Resonant Ripple-Cancellation Loop Filter

This block is the digital loop filter inside a feedback loop that cancels the switching ripple left on the output of a pulse-width-modulated power stage. Each time the loop's sample strobe is high it takes one signed error sample and produces one signed drive sample. The filter's gain is very large at the switching frequency and small in the audio band. Its transfer function is the inverse of a notch-shaped noise transfer function minus one. That form places a resonator with poles on the unit circle exactly at the carrier, which sits at one thirty-second of the loop sample rate.

The recurrence is a second-order direct form I section with coefficients in signed Q2.14 format. The coefficients are computed offline and given as parameters, so their least significant bits can be trimmed to place the resonance. The sum of products is formed in a wide accumulator and scaled back by an arithmetic shift. The result is then clamped to the output range. The clamped value is both the output and the value fed back. The loop around this block already carries three unit delays, so the block adds exactly one register stage between its input and its output.

Top module: `ripple_reso_filter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `drive_out`, `out_valid` and all stored past samples become zero.
- R2: On a strobed edge (`in_valid`=1, `clr`=0), the new output is y = sat(floor((B0·x[n] + B1·x[n−1] + A1·y[n−1] − A2·y[n−2]) / 2^14)). Here x[n] is `err_in`, x[n−1] is the previous strobed input, y[n−1] is the current `drive_out` and y[n−2] is the output before it. The floor is an arithmetic right shift, so negative results round toward minus infinity.
- R3: `drive_out` takes its new value at the same clock edge that samples the strobed input, so there is one cycle of latency. `out_valid` is high for exactly the cycle after each strobed, non-cleared edge and low otherwise.
- R4: On an edge with `in_valid`=0, `err_in` is ignored and `drive_out` and the stored past samples keep their values.
- R5: An edge with `clr`=1 zeroes `drive_out` and all stored past samples, even when `in_valid` is also high. A zero input strobed just after a clear gives a zero output.
- R6: Results are saturated to the signed output range, which is −32768 to 32767 for the default 16-bit width. The saturated value is what is stored for feedback.
- R7: The default coefficients are A1=32138, A2=16384, B0=129 and B1=−131. With these, an input of 16384 followed by zeros from a cleared state gives outputs 129, 122, 110, 93. The input −16384 followed by 0 gives −129, then −123.
- R8: A sustained input at the resonant frequency, a period of 32 strobes, drives the output to both saturation limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loop clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the filter state |
| in_valid | input | 1 | Sample strobe; the filter advances only when it is high |
| err_in | input | DATA_W | Signed error sample |
| drive_out | output | DATA_W | Signed, saturated drive sample (registered) |
| out_valid | output | 1 | High for one cycle after each accepted sample |

## Verification
Every result of this block is due at the first rising edge after the stimulus is applied. A new output, the `out_valid` pulse, the hold when the strobe is low, and the effect of a clear or reset all appear in `drive_out` and `out_valid` one edge later. The bench drives its inputs on falling edges, lets exactly one rising edge pass, and samples on the following falling edge. Each check therefore compares a registered value that has settled for half a cycle. The resonance test follows the same one-edge rule on every strobe and compares against a sample-by-sample evaluation of the R2 recurrence.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam int unsigned FRAC_BITS = 14;

  // Clamp a wide signed value into a DW-bit signed range (DW <= 32, AW <= 64).
  function automatic logic signed [63:0] rr_clamp(input logic signed [63:0] v, input int unsigned dw);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = (64'sd1 <<< (dw - 1)) - 64'sd1;
    lo = -(64'sd1 <<< (dw - 1));
    if (v > hi)      return hi;
    else if (v < lo) return lo;
    else             return v;
  endfunction
endpackage

// File: rtl/rr_tapline.sv
module rr_tapline #(
  parameter int W     = 16,
  parameter int DEPTH = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr,
  input  logic                      en,
  input  logic [W-1:0]              d,
  output logic [DEPTH-1:0][W-1:0]   q
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [W-1:0] src;
    if (i == 0) begin : g_head
      assign src = d;
    end else begin : g_tail
      assign src = q[i-1];
    end
    always_ff @(posedge clk) begin
      if (rst || clr) q[i] <= '0;
      else if (en)    q[i] <= src;
    end
  end
endmodule

// File: rtl/rr_mac.sv
module rr_mac
  import rr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter logic signed [COEF_W-1:0] B0 = 16'sd129,
  parameter logic signed [COEF_W-1:0] B1 = -16'sd131,
  parameter logic signed [COEF_W-1:0] A1 = 16'sd32138,
  parameter logic signed [COEF_W-1:0] A2 = 16'sd16384
) (
  input  logic signed [DATA_W-1:0] x0,
  input  logic signed [DATA_W-1:0] x1,
  input  logic signed [DATA_W-1:0] y1,
  input  logic signed [DATA_W-1:0] y2,
  output logic signed [DATA_W-1:0] y_new
);
  localparam int ACC_W = DATA_W + COEF_W + 3;

  logic signed [ACC_W-1:0] p_b0, p_b1, p_a1, p_a2, acc, scaled;
  logic signed [63:0]      clamped;

  always_comb begin
    p_b0    = ACC_W'(B0) * ACC_W'(x0);
    p_b1    = ACC_W'(B1) * ACC_W'(x1);
    p_a1    = ACC_W'(A1) * ACC_W'(y1);
    p_a2    = ACC_W'(A2) * ACC_W'(y2);
    acc     = p_b0 + p_b1 + p_a1 - p_a2;
    scaled  = acc >>> FRAC_BITS;
    clamped = rr_clamp(64'(scaled), DATA_W);
    y_new   = clamped[DATA_W-1:0];
  end
endmodule

// File: rtl/ripple_reso_filter.sv
module ripple_reso_filter #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter logic signed [COEF_W-1:0] B0 = 16'sd129,
  parameter logic signed [COEF_W-1:0] B1 = -16'sd131,
  parameter logic signed [COEF_W-1:0] A1 = 16'sd32138,
  parameter logic signed [COEF_W-1:0] A2 = 16'sd16384
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] err_in,
  output logic [DATA_W-1:0] drive_out,
  output logic              out_valid
);
  localparam int X_TAPS = 1;
  localparam int Y_TAPS = 2;

  logic [X_TAPS-1:0][DATA_W-1:0] x_hist;
  logic [Y_TAPS-1:0][DATA_W-1:0] y_hist;
  logic [DATA_W-1:0]             y_next;
  logic                          step;

  assign step = in_valid && !clr;

  rr_tapline #(.W(DATA_W), .DEPTH(X_TAPS)) u_xline (
    .clk(clk), .rst(rst), .clr(clr), .en(in_valid), .d(err_in), .q(x_hist)
  );

  rr_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .B0(B0), .B1(B1), .A1(A1), .A2(A2)) u_mac (
    .x0($signed(err_in)),
    .x1($signed(x_hist[0])),
    .y1($signed(y_hist[0])),
    .y2($signed(y_hist[1])),
    .y_new(y_next)
  );

  rr_tapline #(.W(DATA_W), .DEPTH(Y_TAPS)) u_yline (
    .clk(clk), .rst(rst), .clr(clr), .en(in_valid), .d(y_next), .q(y_hist)
  );

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= step;
  end

  assign drive_out = y_hist[0];
endmodule

// File: rtl/ripple_reso_filter_chk.sv
module ripple_reso_filter_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              clr,
  input logic              in_valid,
  input logic [DATA_W-1:0] err_in,
  input logic [DATA_W-1:0] drive_out,
  input logic              out_valid
);
  AST_RESET_ZERO: assert property (@(posedge clk) $past(rst) |-> (drive_out == '0 && !out_valid)); // R1
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst) (in_valid && !clr) |=> out_valid); // R3
  AST_NO_STROBE_QUIET: assert property (@(posedge clk) disable iff (rst) !(in_valid && !clr) |=> !out_valid); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) (!in_valid && !clr) |=> $stable(drive_out)); // R4
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst) clr |=> drive_out == '0); // R5
  AST_ZERO_AFTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ($past(clr) && !clr && in_valid && err_in == '0) |=> drive_out == '0); // R5
endmodule

bind ripple_reso_filter ripple_reso_filter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid),
  .err_in(err_in), .drive_out(drive_out), .out_valid(out_valid)
);

// File: tb/test_ripple_reso_filter.sv
`timescale 1ns/1ps
module test_ripple_reso_filter;
  localparam int DW = 16;
  localparam int YMAX = 32767;
  localparam int YMIN = -32768;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] err_in = '0;
  logic [DW-1:0] drive_out;
  logic out_valid;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #4 clk = ~clk;  // 125 MHz

  ripple_reso_filter i_ripple_reso_filter (
    .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid),
    .err_in(err_in), .drive_out(drive_out), .out_valid(out_valid)
  );

  typedef struct packed {
    logic clr;
    logic vld;
    int   x;
    int   y;
    logic ov;
  } vec_t;

  // R7/R2/R4/R5 directed sequence from a freshly reset state
  localparam vec_t VEC [10] = '{
    '{1'b0, 1'b1, 16384,  129,  1'b1},   // R7 impulse
    '{1'b0, 1'b1, 0,      122,  1'b1},   // R7
    '{1'b0, 1'b0, 5000,   122,  1'b0},   // R4 ignored input
    '{1'b0, 1'b1, 0,      110,  1'b1},   // R7
    '{1'b0, 1'b1, 0,      93,   1'b1},   // R7
    '{1'b1, 1'b1, 7000,   0,    1'b0},   // R5 clear wins
    '{1'b0, 1'b1, 0,      0,    1'b1},   // R5 state cleared
    '{1'b0, 1'b1, -16384, -129, 1'b1},   // R7 negative impulse
    '{1'b0, 1'b1, 0,      -123, 1'b1},   // R2 floor toward -inf
    '{1'b0, 1'b0, -999,   -123, 1'b0}    // R4 hold
  };

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic v, input int x);
    @(negedge clk);
    clr = c; in_valid = v; err_in = DW'(x);
    @(posedge clk);
    @(negedge clk);
    clr = 1'b0; in_valid = 1'b0;
  endtask

  // Spec evaluation of the R2 recurrence with default R7 coefficients
  int m_x1 = 0, m_y1 = 0, m_y2 = 0;
  function automatic int spec_next(input int x);
    longint acc;
    longint s;
    acc = 129 * longint'(x) - 131 * longint'(m_x1) + 32138 * longint'(m_y1) - 16384 * longint'(m_y2);
    s = acc >>> 14;
    if (s > YMAX) s = YMAX;
    if (s < YMIN) s = YMIN;
    return int'(s);
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit hit_hi, hit_lo;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset out", int'($signed(drive_out)), 0);
    check("R1 reset valid", int'(out_valid), 0);
    rst = 1'b0;

    foreach (VEC[i]) begin
      drive(VEC[i].clr, VEC[i].vld, VEC[i].x);
      check($sformatf("R2/R7 vec%0d out", i), int'($signed(drive_out)), VEC[i].y);
      check($sformatf("R3 vec%0d valid", i), int'(out_valid), int'(VEC[i].ov));
    end

    // R8/R6: resonant input, compared with the spec on every strobe
    drive(1'b1, 1'b0, 0);
    m_x1 = 0; m_y1 = 0; m_y2 = 0;
    hit_hi = 0; hit_lo = 0;
    for (int n = 0; n < 1500; n++) begin
      int x, e;
      x = $rtoi(20000.0 * $sin(2.0 * 3.14159265358979 * n / 32.0));
      e = spec_next(x);
      drive(1'b0, 1'b1, x);
      m_x1 = x; m_y2 = m_y1; m_y1 = e;
      check("R6 resonant sample", int'($signed(drive_out)), e);
      if ($signed(drive_out) == YMAX) hit_hi = 1;
      if ($signed(drive_out) == YMIN) hit_lo = 1;
      if (n == 700) begin
        drive(1'b0, 1'b0, 12345);  // R4 gap mid-stream
        check("R4 gap hold", int'($signed(drive_out)), m_y1);
      end
    end
    check("R8 reached max", int'(hit_hi), 1);
    check("R8 reached min", int'(hit_lo), 1);

    // R1: reset while state is nonzero, then zero input stays zero
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 mid reset out", int'($signed(drive_out)), 0);
    check("R1 mid reset valid", int'(out_valid), 0);
    rst = 1'b0;
    drive(1'b0, 1'b1, 0);
    check("R1 state cleared", int'($signed(drive_out)), 0);
    drive(1'b0, 1'b1, 16384);
    check("R1 fresh impulse", int'($signed(drive_out)), 129);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule